// File: doc/BRIEF.md
# Masked Multi-Line Control Register File

This block holds the control and status words for a set of communication lines, up to sixteen of them, with four words per line. A register address is the line number times four plus a word index in the two low address bits. Words 0, 1 and 2 of each line are control words that software can write. Word 3 is a read-only view of a status word that the serial hardware drives into the block. A parameter marks which lines are fitted. Lines that are not fitted hold no storage and read back as zero.

Software has two ways to change a control word. The first is a plain bus write. The second is an atomic masked update, which names a register with the same line-times-four address. It forces a chosen subset of the register's bits to a single value in one cycle and leaves every other bit as it was. The value comes from the most significant bit of the mask word. The line-servicing logic has a third write port of its own. When two or more sources hit the same register in one cycle, the masked update wins over both other sources, so it stays atomic.

Two enable bits in control word 0 gate the per-line receive and transmit wake-up requests. Clearing both enables with one masked update silences a line and leaves the rest of its configuration intact.

Top module: `mlcr_top`

## Requirements
- R1: After synchronous reset every control word reads 0x0000 and every rx_wake and tx_wake output is 0.
- R2: A bus write to word 0, 1 or 2 of a fitted line (address bits [5:2] = line, [1:0] = word) is read back unchanged on bus_rdata from the next cycle. The one exception is bit [15], covered by R6.
- R3: A read of word 3 of a fitted line returns that line's 16-bit slice line_status[16*line+15 : 16*line]. Writes to word 3, from any source, change no register.
- R4: A line whose bit in the PRESENT_LINES parameter is 0 reads 0x0000 on all four words, including word 3. Writes and masked updates to it have no effect, and it never raises rx_wake or tx_wake.
- R5: A masked update sets each register bit whose mask bit in [14:0] is 1 to the value of mask bit [15]. All other bits keep their value. The result is visible the next cycle.
- R6: Bit [15] of every control word is unused and always reads 0, whatever value is written or masked into it.
- R7: rx_wake[l] is rx_ready[l] AND control-word-0 bit [7] (receive enable). tx_wake[l] is tx_ready[l] AND control-word-0 bit [6] (send enable).
- R8: A masked update to word 0 with mask 0x00C0 clears both enables and leaves all other bits unchanged. From the next cycle the line raises no wake-ups.
- R9: When sources hit the same register in one cycle, the masked update takes priority over the bus write, and the bus write takes priority over the service write.
- R10: Writes from different sources that target different registers in the same cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Plain bus write strobe |
| bus_addr | input | 6 | Bus register address (line*4 + word), used for both read and write |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| svc_wr | input | 1 | Service-side write strobe |
| svc_addr | input | 6 | Service-side register address |
| svc_wdata | input | 16 | Service-side write data |
| mupd_valid | input | 1 | Masked update strobe |
| mupd_addr | input | 6 | Masked update target (line*4 + word) |
| mupd_mask | input | 16 | Bit [15] is the value to force; bits [14:0] select the bits to change |
| line_status | input | 256 | Status word of each line, 16 bits per line |
| rx_ready | input | 16 | Per-line receive service condition from the serial hardware |
| tx_ready | input | 16 | Per-line transmit service condition from the serial hardware |
| rx_wake | output | 16 | Per-line receive wake-up request |
| tx_wake | output | 16 | Per-line transmit wake-up request |

## Verification
A corrupted control word shows on bus_rdata as soon as that address is read, one cycle after the write that caused it. If the corruption hits word 0, it also shows on rx_wake or tx_wake in the same cycle the bad value is held. The tests read every word they touch and its neighbours right after each update, so a bit that is lost, leaked or written to the wrong register is caught within one cycle. For each same-cycle conflict the tests check the value that wins, so a wrong priority order shows as the losing source's value.

// File: rtl/mlcr_pkg.sv
package mlcr_pkg;

    localparam int DW        = 16;
    localparam int WORDS     = 4;
    localparam int CTRL_CNT  = WORDS - 1;
    localparam int WSEL_W    = $clog2(WORDS);
    // bit "0" in MSB-first numbering is the top bit of the word
    localparam int VAL_IDX   = DW - 1;
    localparam int RXEN_IDX  = DW - 1 - 8;
    localparam int TXEN_IDX  = DW - 1 - 9;

    typedef struct packed {
        logic              en;
        logic [WSEL_W-1:0] word;
        logic [DW-1:0]     data;
    } cmd_t;

    localparam logic [DW-1:0] TOP_BIT = {1'b1, {(DW-1){1'b0}}};

    function automatic logic [DW-1:0] scrub(input logic [DW-1:0] d);
        return d & ~TOP_BIT;
    endfunction

    function automatic logic [DW-1:0] masked_next(input logic [DW-1:0] cur,
                                                  input logic [DW-1:0] msk);
        logic [DW-1:0] sel;
        sel = msk & ~TOP_BIT;
        if (msk[VAL_IDX]) return scrub(cur | sel);
        else              return scrub(cur & ~sel);
    endfunction

endpackage

// File: rtl/mlcr_ctrl_word.sv
module mlcr_ctrl_word
    import mlcr_pkg::*;
#(
    parameter int WORD_IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_t          mcmd,
    input  cmd_t          bcmd,
    input  cmd_t          scmd,
    output logic [DW-1:0] q
);
    localparam logic [WSEL_W-1:0] MY_WORD = WSEL_W'(WORD_IDX);

    logic mhit, bhit, shit;
    assign mhit = mcmd.en && (mcmd.word == MY_WORD);
    assign bhit = bcmd.en && (bcmd.word == MY_WORD);
    assign shit = scmd.en && (scmd.word == MY_WORD);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (mhit) q <= masked_next(q, mcmd.data);
        else if (bhit) q <= scrub(bcmd.data);
        else if (shit) q <= scrub(scmd.data);
    end

    // R5
    mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mhit |=> ((q & ~$past(mcmd.data)) == ($past(q) & ~$past(mcmd.data) & ~TOP_BIT)));
    // R5
    mask_force_chk: assert property (@(posedge clk) disable iff (rst)
        mhit |=> ((q & $past(mcmd.data) & ~TOP_BIT) ==
                  ($past(mcmd.data[VAL_IDX]) ? ($past(mcmd.data) & ~TOP_BIT) : '0)));
    // R6
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q[VAL_IDX] == 1'b0));
    // R9
    bus_over_svc_chk: assert property (@(posedge clk) disable iff (rst)
        (bhit && shit && !mhit) |=> (q == ($past(bcmd.data) & ~TOP_BIT)));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(mhit || bhit || shit) |=> $stable(q));

endmodule

// File: rtl/mlcr_line_bank.sv
module mlcr_line_bank
    import mlcr_pkg::*;
#(
    parameter bit PRESENT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  cmd_t                    mcmd,
    input  cmd_t                    bcmd,
    input  cmd_t                    scmd,
    input  logic                    rx_ready_i,
    input  logic                    tx_ready_i,
    output logic [CTRL_CNT-1:0][DW-1:0] ctrl_o,
    output logic                    rx_wake_o,
    output logic                    tx_wake_o
);
    generate
        if (PRESENT) begin : g_fitted
            for (genvar w = 0; w < CTRL_CNT; w++) begin : g_word
                mlcr_ctrl_word #(.WORD_IDX(w)) u_word (
                    .clk  (clk),
                    .rst  (rst),
                    .mcmd (mcmd),
                    .bcmd (bcmd),
                    .scmd (scmd),
                    .q    (ctrl_o[w])
                );
            end

            // R8
            enable_clear_chk: assert property (@(posedge clk) disable iff (rst)
                (mcmd.en && mcmd.word == '0 && !mcmd.data[VAL_IDX] &&
                 mcmd.data[RXEN_IDX] && mcmd.data[TXEN_IDX])
                |=> (!rx_wake_o && !tx_wake_o));
        end else begin : g_absent
            logic unused_cmds;
            assign unused_cmds = ^{mcmd, bcmd, scmd};
            assign ctrl_o = '0;
        end
    endgenerate

    assign rx_wake_o = rx_ready_i & ctrl_o[0][RXEN_IDX];
    assign tx_wake_o = tx_ready_i & ctrl_o[0][TXEN_IDX];

endmodule

// File: rtl/mlcr_top.sv
module mlcr_top
    import mlcr_pkg::*;
#(
    parameter int                   NUM_LINES     = 16,
    parameter logic [NUM_LINES-1:0] PRESENT_LINES = '1,
    localparam int                  LINE_W        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int                  ADDR_W        = LINE_W + WSEL_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic                    svc_wr,
    input  logic [ADDR_W-1:0]       svc_addr,
    input  logic [DW-1:0]           svc_wdata,
    input  logic                    mupd_valid,
    input  logic [ADDR_W-1:0]       mupd_addr,
    input  logic [DW-1:0]           mupd_mask,
    input  logic [NUM_LINES*DW-1:0] line_status,
    input  logic [NUM_LINES-1:0]    rx_ready,
    input  logic [NUM_LINES-1:0]    tx_ready,
    output logic [NUM_LINES-1:0]    rx_wake,
    output logic [NUM_LINES-1:0]    tx_wake
);
    logic [CTRL_CNT-1:0][DW-1:0] line_ctrl [NUM_LINES];

    generate
        for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
            localparam logic [LINE_W-1:0] MY_LINE = LINE_W'(l);
            cmd_t mc, bc, sc;

            assign mc.en   = mupd_valid && (mupd_addr[ADDR_W-1:WSEL_W] == MY_LINE);
            assign mc.word = mupd_addr[WSEL_W-1:0];
            assign mc.data = mupd_mask;
            assign bc.en   = bus_wr && (bus_addr[ADDR_W-1:WSEL_W] == MY_LINE);
            assign bc.word = bus_addr[WSEL_W-1:0];
            assign bc.data = bus_wdata;
            assign sc.en   = svc_wr && (svc_addr[ADDR_W-1:WSEL_W] == MY_LINE);
            assign sc.word = svc_addr[WSEL_W-1:0];
            assign sc.data = svc_wdata;

            mlcr_line_bank #(.PRESENT(PRESENT_LINES[l])) u_bank (
                .clk        (clk),
                .rst        (rst),
                .mcmd       (mc),
                .bcmd       (bc),
                .scmd       (sc),
                .rx_ready_i (rx_ready[l]),
                .tx_ready_i (tx_ready[l]),
                .ctrl_o     (line_ctrl[l]),
                .rx_wake_o  (rx_wake[l]),
                .tx_wake_o  (tx_wake[l])
            );
        end
    endgenerate

    logic [LINE_W-1:0] rd_line;
    logic [WSEL_W-1:0] rd_word;
    assign rd_line = bus_addr[ADDR_W-1:WSEL_W];
    assign rd_word = bus_addr[WSEL_W-1:0];

    always_comb begin
        bus_rdata = '0;
        if (int'(rd_line) < NUM_LINES) begin
            if (PRESENT_LINES[rd_line]) begin
                if (int'(rd_word) == CTRL_CNT)
                    bus_rdata = line_status[int'(rd_line)*DW +: DW];
                else
                    bus_rdata = line_ctrl[rd_line][rd_word[WSEL_W-1:0] & 2'b11];
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (rx_wake == '0 && tx_wake == '0));
    // R4
    absent_silent_chk: assert property (@(posedge clk) disable iff (rst)
        ((rx_wake | tx_wake) & ~PRESENT_LINES) == '0);

endmodule

// File: tb/tb_mlcr_top.sv
module tb_mlcr_top;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 16;
    localparam logic [NL-1:0] PRES = 16'h7F7F;  // lines 7 and 15 absent

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr, svc_wr, mupd_valid;
    logic [5:0]    bus_addr, svc_addr, mupd_addr;
    logic [15:0]   bus_wdata, svc_wdata, mupd_mask, bus_rdata;
    logic [NL*16-1:0] line_status;
    logic [NL-1:0] rx_ready, tx_ready, rx_wake, tx_wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mlcr_top #(.NUM_LINES(NL), .PRESENT_LINES(PRES)) dut (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .svc_wr(svc_wr), .svc_addr(svc_addr), .svc_wdata(svc_wdata),
        .mupd_valid(mupd_valid), .mupd_addr(mupd_addr), .mupd_mask(mupd_mask),
        .line_status(line_status), .rx_ready(rx_ready), .tx_ready(tx_ready),
        .rx_wake(rx_wake), .tx_wake(tx_wake)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ra(input int line, input int word);
        return 6'(line * 4 + word);
    endfunction

    // inputs are changed only just after a falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; svc_wr = 1'b0; mupd_valid = 1'b0;
    endtask

    task automatic bwrite(input logic [5:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
    endtask

    task automatic mupd(input logic [5:0] a, input logic [15:0] m);
        mupd_valid = 1'b1; mupd_addr = a; mupd_mask = m;
        step();
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rx_ready = '1; tx_ready = '1;
        for (int l = 0; l < 4; l++)
            for (int w = 0; w < 3; w++) begin
                rd(ra(l, w), v);
                check("R1 ctrl after reset", v, 16'h0000);
            end
        check("R1 rx_wake after reset", rx_wake, 16'h0000);
        check("R1 tx_wake after reset", tx_wake, 16'h0000);
        rx_ready = '0; tx_ready = '0;
    endtask

    task automatic t_plain();
        logic [15:0] v;
        bwrite(ra(2, 0), 16'h1234);
        bwrite(ra(2, 1), 16'h0ABC);
        bwrite(ra(2, 2), 16'h7001);
        rd(ra(2, 0), v); check("R2 word0 readback", v, 16'h1234);
        rd(ra(2, 1), v); check("R2 word1 readback", v, 16'h0ABC);
        rd(ra(2, 2), v); check("R2 word2 readback", v, 16'h7001);
        rd(ra(3, 0), v); check("R2 neighbour untouched", v, 16'h0000);
        bwrite(ra(2, 1), 16'hFFFF);
        rd(ra(2, 1), v); check("R6 top bit dropped on write", v, 16'h7FFF);
    endtask

    task automatic t_status();
        logic [15:0] v;
        line_status[5*16 +: 16] = 16'hA5C3;
        rd(ra(5, 3), v); check("R3 status read", v, 16'hA5C3);
        bwrite(ra(5, 3), 16'h1111);
        svc_wr = 1'b1; svc_addr = ra(5, 3); svc_wdata = 16'h2222;
        mupd(ra(5, 3), 16'h80FF);
        rd(ra(5, 3), v); check("R3 status after writes", v, 16'hA5C3);
        for (int w = 0; w < 3; w++) begin
            rd(ra(5, w), v); check("R3 ctrl untouched by word3 write", v, 16'h0000);
        end
    endtask

    task automatic t_absent();
        logic [15:0] v;
        line_status[7*16 +: 16] = 16'hBEEF;
        bwrite(ra(7, 0), 16'h00C0);
        mupd(ra(7, 0), 16'h80C0);
        rd(ra(7, 0), v); check("R4 absent word0", v, 16'h0000);
        rd(ra(7, 3), v); check("R4 absent status", v, 16'h0000);
        rx_ready[7] = 1'b1; tx_ready[7] = 1'b1;
        #1;
        check("R4 absent rx_wake", 16'(rx_wake[7]), 16'h0000);
        check("R4 absent tx_wake", 16'(tx_wake[7]), 16'h0000);
        rx_ready[7] = 1'b0; tx_ready[7] = 1'b0;
    endtask

    task automatic t_mask();
        logic [15:0] v;
        bwrite(ra(4, 1), 16'h5A5A);
        mupd(ra(4, 1), 16'h800F);
        rd(ra(4, 1), v); check("R5 masked set", v, 16'h5A5F);
        mupd(ra(4, 1), 16'h00F0);
        rd(ra(4, 1), v); check("R5 masked clear", v, 16'h5A0F);
        mupd(ra(4, 1), 16'h8000);
        rd(ra(4, 1), v); check("R6 empty mask leaves value", v, 16'h5A0F);
        rd(ra(4, 0), v); check("R5 other word untouched", v, 16'h0000);
    endtask

    task automatic t_wake();
        bwrite(ra(1, 0), 16'h12C0);
        rx_ready[1] = 1'b1; tx_ready[1] = 1'b0;
        #1;
        check("R7 rx_wake enabled", 16'(rx_wake[1]), 16'h0001);
        check("R7 tx_wake not ready", 16'(tx_wake[1]), 16'h0000);
        tx_ready[1] = 1'b1;
        #1;
        check("R7 tx_wake enabled", 16'(tx_wake[1]), 16'h0001);
        bwrite(ra(1, 0), 16'h0080);
        check("R7 tx_wake disabled", 16'(tx_wake[1]), 16'h0000);
        check("R7 rx_wake only", 16'(rx_wake[1]), 16'h0001);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        bwrite(ra(1, 0), 16'h12C3);
        check("R8 wakes before clear", 16'(rx_wake[1] & tx_wake[1]), 16'h0001);
        mupd(ra(1, 0), 16'h00C0);
        check("R8 rx_wake after clear", 16'(rx_wake[1]), 16'h0000);
        check("R8 tx_wake after clear", 16'(tx_wake[1]), 16'h0000);
        rd(ra(1, 0), v); check("R8 config kept", v, 16'h1203);
        rx_ready[1] = 1'b0; tx_ready[1] = 1'b0;
    endtask

    task automatic t_conflict();
        logic [15:0] v;
        bwrite(ra(6, 0), 16'h1000);
        mupd_valid = 1'b1; mupd_addr = ra(6, 0); mupd_mask = 16'h8003;
        svc_wr = 1'b1; svc_addr = ra(6, 0); svc_wdata = 16'h0F00;
        bus_wr = 1'b1; bus_addr = ra(6, 0); bus_wdata = 16'h00F0;
        step();
        rd(ra(6, 0), v); check("R9 masked wins", v, 16'h1003);
        svc_wr = 1'b1; svc_addr = ra(6, 2); svc_wdata = 16'h0F00;
        bus_wr = 1'b1; bus_addr = ra(6, 2); bus_wdata = 16'h00F0;
        step();
        rd(ra(6, 2), v); check("R9 bus over service", v, 16'h00F0);
    endtask

    task automatic t_parallel();
        logic [15:0] v;
        mupd_valid = 1'b1; mupd_addr = ra(3, 2); mupd_mask = 16'h8500;
        svc_wr = 1'b1; svc_addr = ra(3, 1); svc_wdata = 16'h0042;
        bus_wr = 1'b1; bus_addr = ra(8, 0); bus_wdata = 16'h0300;
        step();
        rd(ra(3, 2), v); check("R10 masked lands", v, 16'h0500);
        rd(ra(3, 1), v); check("R10 service lands", v, 16'h0042);
        rd(ra(8, 0), v); check("R10 bus lands", v, 16'h0300);
    endtask

    initial begin
        rst = 1'b1;
        bus_wr = 1'b0; svc_wr = 1'b0; mupd_valid = 1'b0;
        bus_addr = '0; svc_addr = '0; mupd_addr = '0;
        bus_wdata = '0; svc_wdata = '0; mupd_mask = '0;
        line_status = '0; rx_ready = '0; tx_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_status();
        t_absent();
        t_mask();
        t_wake();
        t_clear();
        t_conflict();
        t_parallel();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule